// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block decides the outcome of conditional stores in a small multiprocessor with a parameterised number of harts. Each hart has its own reservation, made up of a valid flag and a physical address. A load-locked request records the address and raises the flag. A conditional store then succeeds only while that flag is still set and the store falls in the same aligned granule as the recorded address. The granule is 16 bytes by default.

Every write that reaches memory removes every reservation, on any hart, that covers the written granule. A write here means an ordinary store, a successful conditional store or an uncacheable conditional store. An exception return drops the hart's own reservation. Each hart also counts its consecutive conditional-store failures and raises a one-cycle warning each time that count reaches a whole multiple of a configured period.

The block has no data path. The store and load-locked ports carry only addresses and flags. The block accepts one request per hart per cycle and never applies back-pressure, so it has no ready signals. The result of a conditional store is reported as a 2-bit code with a valid strobe one cycle after the request.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset no reservation is held, `sc_res_vld` and `fail_warn` are low, and a cacheable conditional store with no prior load-locked on that hart returns code 0.
- R2: A load-locked request on a hart followed by a cacheable conditional store from the same hart to the same address returns code 1 (success). The code appears with `sc_res_vld` high in the cycle after the store request.
- R3: The reservation matches on the address with its low GRAN_BITS bits ignored (4 bits by default). A store differing only in those bits succeeds, and a store differing in any higher bit returns code 0.
- R4: A failed cacheable conditional store returns code 0, clears the hart's own reservation and performs no write, so a reservation held by another hart on that granule survives.
- R5: A conditional store with the uncacheable flag set always returns code 2, whatever the reservation state. It resets the hart's consecutive-failure count and counts as a write for clearing reservations.
- R6: An ordinary store, a successful conditional store or an uncacheable conditional store clears the reservation of every hart whose recorded address lies in the same granule. Reservations on other granules are kept.
- R7: An exception-return pulse on a hart clears that hart's reservation.
- R8: When a load-locked request and a write by another hart to the same granule occur in the same cycle, the reservation ends up cleared. The same holds for any other clear source in that cycle.
- R9: `fail_warn` for a hart pulses for exactly one cycle, together with the result, on the conditional-store failure that brings that hart's consecutive-failure count to a multiple of WARN_PERIOD. A success or an uncacheable conditional store restarts the count.
- R10: `sc_res_vld` is raised only for conditional stores, never for ordinary stores, and the code is never 3. Codes are 0 for fail, 1 for success and 2 for uncacheable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_vld | input | HARTS | Load-locked request per hart |
| ll_addr | input | HARTS*AW | Load-locked physical address, hart h at bits [h*AW +: AW] |
| st_vld | input | HARTS | Store request per hart |
| st_cond | input | HARTS | Store is conditional |
| st_uncached | input | HARTS | Store target is uncacheable |
| st_addr | input | HARTS*AW | Store physical address, hart h at bits [h*AW +: AW] |
| exc_ret | input | HARTS | Exception-return pulse per hart |
| sc_res_vld | output | HARTS | Conditional-store result strobe |
| sc_res_code | output | HARTS*2 | Result code, hart h at bits [2h +: 2] |
| fail_warn | output | HARTS | Consecutive-failure warning pulse |

## Verification
The hardest situation to reach is the same-cycle race between a new load-locked request and a write from another hart to that granule. A neighbouring race is a failed conditional store that must leave another hart's reservation intact. The stimulus drives several harts in one cycle and then probes each reservation with a conditional store. The warning needs long runs of consecutive failures, so the bench uses a small WARN_PERIOD and interleaves successes and uncacheable stores to restart the count. A per-hart reference of flags, addresses and failure phases produces the expected result for every cycle.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    SC_FAIL     = 2'd0,
    SC_OK       = 2'd1,
    SC_UNCACHED = 2'd2
  } sc_code_e;
endpackage

// File: rtl/lrsc_fail_meter.sv
module lrsc_fail_meter #(
  parameter int WARN_PERIOD = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_i,
  input  logic restart_i,
  output logic warn_o
);
  localparam int CW = $clog2(WARN_PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(WARN_PERIOD - 1);

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= '0;
      warn_o <= 1'b0;
    end else begin
      warn_o <= 1'b0;
      if (fail_i) begin
        if (phase == LAST) begin
          phase  <= '0;
          warn_o <= 1'b1;
        end else begin
          phase <= phase + 1'b1;
        end
      end else if (restart_i) begin
        phase <= '0;
      end
    end
  end

  p_warn_follows_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    warn_o |-> $past(fail_i));
  p_warn_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    warn_o |=> !warn_o || (WARN_PERIOD == 1));
endmodule

// File: rtl/lrsc_hart_slot.sv
module lrsc_hart_slot
  import lrsc_pkg::*;
#(
  parameter int HARTS       = 4,
  parameter int AW          = 32,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_PERIOD = 100000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ll_vld_i,
  input  logic [AW-1:0]       ll_addr_i,
  input  logic                st_vld_i,
  input  logic                st_cond_i,
  input  logic                st_uc_i,
  input  logic [AW-1:0]       st_addr_i,
  input  logic                exc_ret_i,
  input  logic [HARTS-1:0]    wr_all_i,
  input  logic [HARTS*AW-1:0] wr_addr_all_i,
  output logic                wr_o,
  output logic                res_vld_o,
  output logic [1:0]          res_code_o,
  output logic                warn_o
);
  localparam int TW = AW - GRAN_BITS;

  logic          flag;
  logic [AW-1:0] rsv_addr;
  logic          sc_cached, sc_ok, sc_fail;
  logic          hit_old, hit_new;

  assign sc_cached = st_vld_i && st_cond_i && !st_uc_i;
  assign sc_ok     = sc_cached && flag &&
                     (rsv_addr[AW-1:GRAN_BITS] == st_addr_i[AW-1:GRAN_BITS]);
  assign sc_fail   = sc_cached && !sc_ok;
  assign wr_o      = st_vld_i && (!st_cond_i || st_uc_i || sc_ok);

  always_comb begin
    hit_old = 1'b0;
    hit_new = 1'b0;
    for (int k = 0; k < HARTS; k++) begin
      if (wr_all_i[k]) begin
        if (wr_addr_all_i[k*AW+GRAN_BITS +: TW] == rsv_addr[AW-1:GRAN_BITS])
          hit_old = 1'b1;
        if (wr_addr_all_i[k*AW+GRAN_BITS +: TW] == ll_addr_i[AW-1:GRAN_BITS])
          hit_new = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag       <= 1'b0;
      rsv_addr   <= '0;
      res_vld_o  <= 1'b0;
      res_code_o <= SC_FAIL;
    end else begin
      if (ll_vld_i) begin
        rsv_addr <= ll_addr_i;
        flag     <= !(exc_ret_i || sc_fail || hit_new);
      end else if (exc_ret_i || sc_fail || hit_old) begin
        flag <= 1'b0;
      end
      res_vld_o <= st_vld_i && st_cond_i;
      if (st_uc_i)    res_code_o <= SC_UNCACHED;
      else if (sc_ok) res_code_o <= SC_OK;
      else            res_code_o <= SC_FAIL;
    end
  end

  lrsc_fail_meter #(.WARN_PERIOD(WARN_PERIOD)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .fail_i    (sc_fail),
    .restart_i (st_vld_i && st_cond_i && (st_uc_i || sc_ok)),
    .warn_o    (warn_o)
  );

  p_fail_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && res_code_o == SC_FAIL) |-> !flag);
  p_eret_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ret_i |=> !flag);
  p_uc_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_vld_i && st_cond_i && st_uc_i) |=> (res_vld_o && res_code_o == SC_UNCACHED));
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_vld_i && hit_new) |=> !flag);
  p_result_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_vld_i && st_cond_i) |=> res_vld_o);
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int HARTS       = 4,
  parameter int AW          = 32,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_PERIOD = 100000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HARTS-1:0]    ll_vld,
  input  logic [HARTS*AW-1:0] ll_addr,
  input  logic [HARTS-1:0]    st_vld,
  input  logic [HARTS-1:0]    st_cond,
  input  logic [HARTS-1:0]    st_uncached,
  input  logic [HARTS*AW-1:0] st_addr,
  input  logic [HARTS-1:0]    exc_ret,
  output logic [HARTS-1:0]    sc_res_vld,
  output logic [HARTS*2-1:0]  sc_res_code,
  output logic [HARTS-1:0]    fail_warn
);
  logic [HARTS-1:0] wr_vec;

  for (genvar h = 0; h < HARTS; h++) begin : g_hart
    lrsc_hart_slot #(
      .HARTS(HARTS), .AW(AW), .GRAN_BITS(GRAN_BITS), .WARN_PERIOD(WARN_PERIOD)
    ) u_slot (
      .clk           (clk),
      .rst_n         (rst_n),
      .ll_vld_i      (ll_vld[h]),
      .ll_addr_i     (ll_addr[h*AW +: AW]),
      .st_vld_i      (st_vld[h]),
      .st_cond_i     (st_cond[h]),
      .st_uc_i       (st_uncached[h]),
      .st_addr_i     (st_addr[h*AW +: AW]),
      .exc_ret_i     (exc_ret[h]),
      .wr_all_i      (wr_vec),
      .wr_addr_all_i (st_addr),
      .wr_o          (wr_vec[h]),
      .res_vld_o     (sc_res_vld[h]),
      .res_code_o    (sc_res_code[2*h +: 2]),
      .warn_o        (fail_warn[h])
    );

    p_code_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sc_res_vld[h] |-> (sc_res_code[2*h +: 2] != 2'd3));
    p_plain_store_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_vld[h] && !st_cond[h]) |=> !sc_res_vld[h]);
    p_warn_with_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fail_warn[h] |-> (sc_res_vld[h] && sc_res_code[2*h +: 2] == 2'd0));
  end
endmodule

// File: tb/lrsc_monitor_bench.sv
module lrsc_monitor_bench;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int GB = 4;
  localparam int WP = 4;

  typedef struct {
    logic [N-1:0]      vld;
    logic [N-1:0][1:0] code;
    logic [N-1:0]      warn;
    string             tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]         ll_vld, st_vld, st_cond, st_uc, exc_ret;
  logic [N-1:0][AW-1:0] ll_addr, st_addr;
  logic [N-1:0]         res_vld, warn;
  logic [N-1:0][1:0]    res_code;

  lrsc_monitor #(.HARTS(N), .AW(AW), .GRAN_BITS(GB), .WARN_PERIOD(WP)) u_lrsc_monitor (
    .clk(clk), .rst_n(rst_n), .ll_vld(ll_vld), .ll_addr(ll_addr),
    .st_vld(st_vld), .st_cond(st_cond), .st_uncached(st_uc), .st_addr(st_addr),
    .exc_ret(exc_ret), .sc_res_vld(res_vld), .sc_res_code(res_code), .fail_warn(warn)
  );

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  logic [N-1:0]         r_flag;
  logic [N-1:0][AW-1:0] r_addr;
  int                   r_phase [N];

  function automatic logic same_g(logic [AW-1:0] a, logic [AW-1:0] b);
    return a[AW-1:GB] == b[AW-1:GB];
  endfunction

  task automatic clear_in();
    ll_vld = '0; st_vld = '0; st_cond = '0; st_uc = '0; exc_ret = '0;
    ll_addr = '0; st_addr = '0;
  endtask

  task automatic do_ll(int h, logic [AW-1:0] a);
    ll_vld[h] = 1'b1; ll_addr[h] = a;
  endtask
  task automatic do_sc(int h, logic [AW-1:0] a, logic uc);
    st_vld[h] = 1'b1; st_cond[h] = 1'b1; st_uc[h] = uc; st_addr[h] = a;
  endtask
  task automatic do_st(int h, logic [AW-1:0] a);
    st_vld[h] = 1'b1; st_addr[h] = a;
  endtask

  // Driver: computes expectation from the reference, pushes it, applies inputs for one cycle.
  task automatic step(string tag);
    exp_t e;
    logic [N-1:0] ok, fl, wr;
    e.tag = tag; e.vld = '0; e.code = '0; e.warn = '0;
    for (int h = 0; h < N; h++) begin
      ok[h] = st_vld[h] && st_cond[h] && !st_uc[h] && r_flag[h] && same_g(r_addr[h], st_addr[h]);
      fl[h] = st_vld[h] && st_cond[h] && !st_uc[h] && !ok[h];
      wr[h] = st_vld[h] && (!st_cond[h] || st_uc[h] || ok[h]);
      e.vld[h]  = st_vld[h] && st_cond[h];
      e.code[h] = st_uc[h] ? 2'd2 : (ok[h] ? 2'd1 : 2'd0);
    end
    for (int h = 0; h < N; h++) begin
      logic ho, hn;
      ho = 1'b0; hn = 1'b0;
      for (int k = 0; k < N; k++) begin
        if (wr[k] && same_g(st_addr[k], r_addr[h])) ho = 1'b1;
        if (wr[k] && same_g(st_addr[k], ll_addr[h])) hn = 1'b1;
      end
      if (fl[h]) begin
        if (r_phase[h] == WP - 1) begin r_phase[h] = 0; e.warn[h] = 1'b1; end
        else r_phase[h]++;
      end else if (e.vld[h]) r_phase[h] = 0;
      if (ll_vld[h]) begin
        r_addr[h] = ll_addr[h];
        r_flag[h] = !(exc_ret[h] || fl[h] || hn);
      end else if (exc_ret[h] || fl[h] || ho) r_flag[h] = 1'b0;
    end
    q.push_back(e);
    @(negedge clk);
    clear_in();
  endtask

  // Monitor: compares outputs just after each active edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        logic bad;
        e = q.pop_front();
        bad = (res_vld != e.vld) || (warn != e.warn);
        for (int h = 0; h < N; h++)
          if (e.vld[h] && res_code[h] != e.code[h]) bad = 1'b1;
        checks++;
        if (bad) begin
          errors++;
          $display("FAIL %s: vld=%b code=%h warn=%b expected vld=%b code=%h warn=%b",
                   e.tag, res_vld, res_code, warn, e.vld, e.code, e.warn);
        end
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_in();
    r_flag = '0; r_addr = '0;
    for (int h = 0; h < N; h++) r_phase[h] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at the ports
    checks++;
    if (res_vld !== '0 || warn !== '0) begin
      errors++;
      $display("FAIL R1: vld=%b warn=%b expected 0 0", res_vld, warn);
    end
    do_sc(0, 16'h1230, 1'b0); step("R1");
    // R2 / R3: success, low bits ignored
    do_ll(0, 16'h1230); step("R2");
    do_sc(0, 16'h123C, 1'b0); step("R3");
    do_ll(1, 16'h2000); step("R2");
    do_sc(1, 16'h2010, 1'b0); step("R3");
    do_sc(1, 16'h2000, 1'b0); step("R4");
    // R6: ordinary store clears matching harts only
    do_ll(2, 16'h3000); do_ll(3, 16'h3008); do_ll(1, 16'h4000); step("R6");
    do_st(0, 16'h3004); step("R6");
    do_sc(2, 16'h3000, 1'b0); do_sc(3, 16'h3008, 1'b0); do_sc(1, 16'h4000, 1'b0); step("R6");
    // R6: successful SC clears other hart
    do_ll(0, 16'h5000); do_ll(1, 16'h5008); step("R6");
    do_sc(0, 16'h5000, 1'b0); step("R6");
    do_sc(1, 16'h5008, 1'b0); step("R6");
    // R4: failed SC does not write
    do_ll(2, 16'h6000); step("R4");
    do_sc(3, 16'h6000, 1'b0); step("R4");
    do_sc(2, 16'h6004, 1'b0); step("R4");
    // R5: uncacheable
    do_sc(0, 16'h0100, 1'b1); step("R5");
    do_ll(1, 16'h7000); step("R5");
    do_sc(0, 16'h7000, 1'b1); step("R5");
    do_sc(1, 16'h7000, 1'b0); step("R5");
    // R7: exception return
    do_ll(3, 16'h8000); step("R7");
    exc_ret[3] = 1'b1; step("R7");
    do_sc(3, 16'h8000, 1'b0); step("R7");
    // R8: same-cycle race
    do_ll(2, 16'h9000); do_st(0, 16'h9004); step("R8");
    do_sc(2, 16'h9000, 1'b0); step("R8");
    do_ll(2, 16'h9000); do_st(0, 16'hA000); step("R8");
    do_sc(2, 16'h9000, 1'b0); step("R8");
    do_ll(1, 16'hB000); exc_ret[1] = 1'b1; step("R8");
    do_sc(1, 16'hB000, 1'b0); step("R8");
    // R9: warning period and restart
    do_sc(1, 16'h0000, 1'b1); step("R9");
    for (int i = 0; i < WP; i++) begin do_sc(1, 16'hC000, 1'b0); step("R9"); end
    for (int i = 0; i < WP - 1; i++) begin do_sc(1, 16'hC000, 1'b0); step("R9"); end
    do_ll(1, 16'hC000); step("R9");
    do_sc(1, 16'hC000, 1'b0); step("R9");
    for (int i = 0; i < WP + 1; i++) begin do_sc(1, 16'hC000, 1'b0); step("R9"); end
    for (int i = 0; i < 2; i++) begin do_sc(1, 16'hC000, 1'b0); step("R9"); end
    do_sc(1, 16'hC000, 1'b1); step("R9");
    for (int i = 0; i < WP; i++) begin do_sc(1, 16'hC000, 1'b0); step("R9"); end
    // R10: ordinary stores give no strobe; multi-hart mix
    do_st(2, 16'hD000); do_st(3, 16'hD010); step("R10");
    do_ll(0, 16'hE000); do_ll(3, 16'hE000); step("R10");
    do_sc(0, 16'hE000, 1'b0); do_sc(3, 16'hE00F, 1'b0); step("R10");
    step("R10");
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule